// File: doc/BRIEF.md
# Command-Driven Parallel Flash Device Model

This block models the device side of a byte-wide parallel NOR flash that is controlled by command bytes. A host writes command bytes over a simple synchronous bus. The block keeps a read mode: array contents, identifier bytes or status. Reads return data according to that mode, so the same address can give different data depending on the last command.

Two operations change the internal memory. Block erase sets every byte of one block to 0xFF. Byte program can only clear bits. Each one runs for a fixed number of clock cycles set by a parameter. While an operation runs, reads return status with the ready bit low.

Writes are accepted only while a write gate is open. A pulse on the kick input opens the gate for a fixed window.

Top module: `flash_cmd_emu`

## Requirements
- R1: After reset the block is in array mode, every memory byte reads 0xFF, and the status shows ready with both error bits clear.
- R2: Command 0x90 selects identifier mode. Address 0 returns the manufacturer byte. The device byte appears at address 1 when LARGE_PART=0 (ID 0x89A6) and at address 2 when LARGE_PART=1 (ID 0xB0D4). Every other address returns 0x00.
- R3: Command 0xFF selects array mode, in which a read returns the stored byte at the bus address.
- R4: Command 0x70 selects status mode. In status mode a read returns bit 7 = ready, bit 5 = erase error, bit 4 = program error, and all other bits 0.
- R5: Command 0x50 clears both error bits and leaves the mode unchanged.
- R6: Block erase is 0x20 followed by the confirm byte 0xD0, both written inside the target block of 2^BLOCK_W bytes. When the erase completes, every byte of that block reads 0xFF and bytes outside the block keep their values.
- R7: Byte program is 0x40 followed by the data byte, written to the target address. The stored byte becomes old AND data. After the data byte the block is in status mode.
- R8: A program that would change any bit from 0 to 1 sets the program-error bit (status bit 4).
- R9: If the byte that follows 0x20 is not 0xD0, the erase is aborted, no memory changes, and both status bits 4 and 5 are set.
- R10: A write is ignored unless the gate is open. A kick opens the gate for GATE_CYC cycles, starting with the next clock.
- R11: An erase is busy for ERASE_CYC cycles and a program for PROG_CYC cycles. While busy, every read returns status with bit 7 = 0, and any written byte other than 0x70 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_kick | input | 1 | Opens the write gate for GATE_CYC cycles |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 8 | Command or data byte |
| bus_rdata | output | 8 | Read data, chosen by mode and busy state |

## Verification
The hardest case to reach is a command written while an operation is still busy, because the window is only a few cycles long. The bench writes 0xFF at once after an erase confirm, so the write lands inside the busy window. It then checks that the block is still in status mode after completion. The busy length is measured by counting the read samples that show the ready bit low after the start. Gate expiry is reached by stopping the kick and idling longer than the window before writing.

// File: rtl/flash_pkg.sv
package flash_pkg;
   typedef enum logic [1:0] {MD_ARRAY, MD_IDENT, MD_STATUS} rd_mode_t;
   typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_PROG} pend_t;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_ARRAY  = 8'hFF;
   localparam logic [7:0] CMD_STATUS = 8'h70;
   localparam logic [7:0] CMD_CLRERR = 8'h50;
   localparam logic [7:0] CMD_ERASE  = 8'h20;
   localparam logic [7:0] CMD_CONF   = 8'hD0;
   localparam logic [7:0] CMD_PROG   = 8'h40;
endpackage

// File: rtl/flash_gate.sv
module flash_gate #(
   parameter int GATE_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic open_o
);
   localparam int CW = $clog2(GATE_CYC + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (kick)              cnt <= CW'(GATE_CYC);
      else if (cnt != '0)         cnt <= cnt - 1'b1;
   end
   assign open_o = (cnt != '0);

   AST_GATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> open_o); // R10
   AST_GATE_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!kick && !open_o) |=> !open_o); // R10
endmodule

// File: rtl/flash_timer.sv
module flash_timer #(
   parameter int ERASE_CYC = 64,
   parameter int PROG_CYC  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_erase,
   output logic busy,
   output logic done
);
   localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int TW   = $clog2(MAXC + 1);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= is_erase ? TW'(ERASE_CYC) : TW'(PROG_CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end
   assign busy = (cnt != '0);
   assign done = (cnt == TW'(1));

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R11
endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int ADDR_W  = 8,
   parameter int BLOCK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_go,
   input  logic              prog_go,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        op_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              prog_fault
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int BN_W  = ADDR_W - BLOCK_W;
   logic [7:0] mem [DEPTH];
   logic [BN_W-1:0] blk;

   assign blk = op_addr[ADDR_W-1:BLOCK_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (erase_go) begin
         for (int i = 0; i < DEPTH; i++)
            if ((i >> BLOCK_W) == int'(blk)) mem[i] <= 8'hFF;
      end else if (prog_go) begin
         mem[op_addr] <= mem[op_addr] & op_data;
      end
   end

   assign rd_data    = mem[rd_addr];
   assign prog_fault = |(~mem[op_addr] & op_data);
endmodule

// File: rtl/flash_cmd_emu.sv
module flash_cmd_emu #(
   parameter int ADDR_W     = 8,
   parameter int BLOCK_W    = 6,
   parameter bit LARGE_PART = 1'b0,
   parameter int ERASE_CYC  = 64,
   parameter int PROG_CYC   = 8,
   parameter int GATE_CYC   = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_kick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   import flash_pkg::*;

   if (BLOCK_W >= ADDR_W || BLOCK_W < 2) begin : g_bad_block
      $error("BLOCK_W must be at least 2 and below ADDR_W");
   end
   if (ERASE_CYC < 1 || PROG_CYC < 1 || GATE_CYC < 1) begin : g_bad_cyc
      $error("cycle counts must be positive");
   end

   logic [7:0] id_man, id_dev;
   logic [ADDR_W-1:0] id_dev_addr;
   if (LARGE_PART) begin : g_id_large
      assign id_man = 8'hB0;
      assign id_dev = 8'hD4;
      assign id_dev_addr = ADDR_W'(2);
   end else begin : g_id_small
      assign id_man = 8'h89;
      assign id_dev = 8'hA6;
      assign id_dev_addr = ADDR_W'(1);
   end

   rd_mode_t          mode;
   pend_t             pend;
   logic              err_erase, err_prog;
   logic [ADDR_W-1:0] op_addr;
   logic [7:0]        op_data;
   logic              op_erase;
   logic              gate_open, busy, done, fault, wr_ok, start, start_erase;
   logic [7:0]        arr_data, stat_byte;

   flash_gate #(.GATE_CYC(GATE_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .kick(gate_kick), .open_o(gate_open));

   assign wr_ok       = bus_we & gate_open;
   assign start_erase = wr_ok & ~busy & (pend == PD_ERASE) & (bus_wdata == CMD_CONF);
   assign start       = start_erase | (wr_ok & ~busy & (pend == PD_PROG));

   flash_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .is_erase(start_erase),
      .busy(busy), .done(done));

   flash_array #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .erase_go(done & op_erase), .prog_go(done & ~op_erase),
      .op_addr(op_addr), .op_data(op_data),
      .rd_addr(bus_addr), .rd_data(arr_data), .prog_fault(fault));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= MD_ARRAY;
         pend      <= PD_NONE;
         err_erase <= 1'b0;
         err_prog  <= 1'b0;
         op_addr   <= '0;
         op_data   <= '0;
         op_erase  <= 1'b0;
      end else begin
         if (done && !op_erase && fault) err_prog <= 1'b1;
         if (wr_ok) begin
            if (busy) begin
               if (bus_wdata == CMD_STATUS) mode <= MD_STATUS;
            end else begin
               unique case (pend)
                  PD_NONE: begin
                     unique case (bus_wdata)
                        CMD_IDENT:  mode <= MD_IDENT;
                        CMD_ARRAY:  mode <= MD_ARRAY;
                        CMD_STATUS: mode <= MD_STATUS;
                        CMD_CLRERR: begin
                           err_erase <= 1'b0;
                           err_prog  <= 1'b0;
                        end
                        CMD_ERASE:  pend <= PD_ERASE;
                        CMD_PROG:   pend <= PD_PROG;
                        default: ;
                     endcase
                  end
                  PD_ERASE: begin
                     pend <= PD_NONE;
                     mode <= MD_STATUS;
                     if (bus_wdata == CMD_CONF) begin
                        op_addr  <= bus_addr;
                        op_erase <= 1'b1;
                     end else begin
                        err_erase <= 1'b1;
                        err_prog  <= 1'b1;
                     end
                  end
                  default: begin
                     pend     <= PD_NONE;
                     mode     <= MD_STATUS;
                     op_addr  <= bus_addr;
                     op_data  <= bus_wdata;
                     op_erase <= 1'b0;
                  end
               endcase
            end
         end
      end
   end

   assign stat_byte = {~busy, 1'b0, err_erase, err_prog, 4'b0000};

   always_comb begin
      if (busy) bus_rdata = stat_byte;
      else begin
         unique case (mode)
            MD_IDENT:  bus_rdata = (bus_addr == '0) ? id_man :
                                   (bus_addr == id_dev_addr) ? id_dev : 8'h00;
            MD_STATUS: bus_rdata = stat_byte;
            default:   bus_rdata = arr_data;
         endcase
      end
   end

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !bus_rdata[7]); // R11
   AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !busy && pend == PD_NONE && bus_wdata == CMD_CLRERR)
      |=> (!err_erase && !err_prog)); // R5
   AST_IDENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !busy && pend == PD_NONE && bus_wdata == CMD_IDENT)
      |=> mode == MD_IDENT); // R2
   AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !busy && pend == PD_ERASE && bus_wdata != CMD_CONF)
      |=> (err_erase && err_prog && !busy)); // R9
   AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open) |-> !start); // R10
endmodule

// File: tb/tb_flash_cmd_emu.sv
`timescale 1ns/1ps
module tb_flash_cmd_emu;
   localparam int AW = 8, BW = 6, EC = 20, PC = 5, GC = 30;
   localparam int NV = 37;
   logic clk = 0, rst_n = 0, kick = 0, we = 0;
   logic [AW-1:0] addr = '0;
   logic [7:0] wdata = '0, rdata, rdata_l;
   int n_run = 0, n_fail = 0, wd = 0;

   always #4 clk = ~clk;

   flash_cmd_emu #(.ADDR_W(AW), .BLOCK_W(BW), .LARGE_PART(1'b0), .ERASE_CYC(EC),
      .PROG_CYC(PC), .GATE_CYC(GC)) dut (
      .clk(clk), .rst_n(rst_n), .gate_kick(kick), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata));
   flash_cmd_emu #(.ADDR_W(AW), .BLOCK_W(BW), .LARGE_PART(1'b1), .ERASE_CYC(EC),
      .PROG_CYC(PC), .GATE_CYC(GC)) dut_l (
      .clk(clk), .rst_n(rst_n), .gate_kick(kick), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_l));

   // {op, addr, byte}: op 0 = write, 1 = read and compare, 2 = wait for ready
   localparam logic [17:0] VEC [NV] = '{
      {2'd1, 8'h00, 8'hFF},                         // R1 erased array
      {2'd0, 8'h00, 8'h70}, {2'd1, 8'h00, 8'h80},   // R1 R4 status
      {2'd0, 8'h00, 8'h90}, {2'd1, 8'h00, 8'h89},   // R2
      {2'd1, 8'h01, 8'hA6}, {2'd1, 8'h02, 8'h00},   // R2
      {2'd0, 8'h00, 8'hFF}, {2'd1, 8'h01, 8'hFF},   // R3
      {2'd0, 8'h10, 8'h40}, {2'd0, 8'h10, 8'h5A}, {2'd2, 8'h00, 8'h00},
      {2'd1, 8'h10, 8'h80},                         // R7 status mode after program
      {2'd0, 8'h00, 8'hFF}, {2'd1, 8'h10, 8'h5A},   // R7
      {2'd0, 8'h50, 8'h40}, {2'd0, 8'h50, 8'h3C}, {2'd2, 8'h00, 8'h00},
      {2'd0, 8'h00, 8'hFF}, {2'd1, 8'h50, 8'h3C},   // R7 other block
      {2'd0, 8'h10, 8'h40}, {2'd0, 8'h10, 8'hFF}, {2'd2, 8'h00, 8'h00},
      {2'd1, 8'h00, 8'h90},                         // R8 program error
      {2'd0, 8'h00, 8'h50}, {2'd1, 8'h00, 8'h80},   // R5
      {2'd0, 8'h00, 8'hFF}, {2'd1, 8'h10, 8'h5A},   // R7 AND result
      {2'd0, 8'h05, 8'h20}, {2'd0, 8'h05, 8'hD0}, {2'd2, 8'h00, 8'h00},
      {2'd0, 8'h00, 8'hFF}, {2'd1, 8'h10, 8'hFF},   // R6 block 0 erased
      {2'd1, 8'h50, 8'h3C},                         // R6 block 1 kept
      {2'd0, 8'h50, 8'h20}, {2'd0, 8'h50, 8'h33},
      {2'd1, 8'h00, 8'hB0}                          // R9
   };

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1;
      @(negedge clk); we = 0;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
      @(negedge clk); addr = a; #1;
      chk(req, rdata, exp);
   endtask

   task automatic wait_ready();
      int k = 0;
      @(negedge clk); #1;
      while (!rdata[7] && k < 1000) begin k++; @(negedge clk); #1; end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1;
      kick = 1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][17:16] == 2'd0) wr(VEC[i][15:8], VEC[i][7:0]);
         else if (VEC[i][17:16] == 2'd1) rd_chk("vector", VEC[i][15:8], VEC[i][7:0]);
         else wait_ready();
      end
      wr(8'h00, 8'h50);
      // R2 large identifier on second instance
      wr(8'h00, 8'h90);
      @(negedge clk); addr = 8'h00; #1; chk("R2 large man", rdata_l, 8'hB0);
      @(negedge clk); addr = 8'h02; #1; chk("R2 large dev", rdata_l, 8'hD4);
      @(negedge clk); addr = 8'h01; #1; chk("R2 large off1", rdata_l, 8'h00);
      // R11 program busy length
      wr(8'h00, 8'hFF);
      wr(8'h20, 8'h40);
      wr(8'h20, 8'hF0);
      #1; cnt = 0;
      while (!rdata[7] && cnt < 1000) begin cnt++; @(negedge clk); #1; end
      chk("R11 prog busy cycles", 8'(cnt), 8'(PC));
      // R11 erase busy: write during busy is ignored, status mode kept
      wr(8'h00, 8'hFF);
      wr(8'hC0, 8'h20);
      wr(8'hC0, 8'hD0);
      #1; chk("R11 busy read", rdata & 8'h80, 8'h00);
      wr(8'h00, 8'hFF);
      wait_ready();
      rd_chk("R11 ignored command", 8'h20, 8'h80);
      // R10 gate expiry
      wr(8'h00, 8'hFF);
      kick = 0;
      repeat (GC + 2) @(negedge clk);
      wr(8'h00, 8'h70);
      rd_chk("R10 closed gate", 8'h20, 8'hF0);
      @(negedge clk); kick = 1; @(negedge clk); kick = 0;
      wr(8'h00, 8'h70);
      rd_chk("R10 open gate", 8'h20, 8'h80);
      // R1 reset returns erased array and array mode
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
      rd_chk("R1 after reset", 8'h20, 8'hFF);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule